// File: doc/BRIEF.md
# Fault-Absorbing Token Balancer Cascade

This block carries tokens on N parallel lanes. A token is a single-cycle pulse, and a lane carries at most one token per cycle. Tokens first pass through an upstream balancing network built from `UP_BLOCKS` stages. Each balancer in that network can be forced into a broken state by a test input. The tokens then pass through `FIX_STAGES` correction stages that no fault can reach.

Every stage is a butterfly of two-input balancers with log2(N) layers. The first layer of a stage pairs the lowest lane with the highest lane. Each later layer pairs lanes inside groups that are half as large as in the layer before. A balancer alternates lone tokens between its two outputs. This brings the most-loaded and least-loaded lanes together, so each stage removes part of the imbalance that faults leave behind.

When there are at least log2(N) correction stages, the counts at the output form an exact step sequence again once traffic has drained. This holds whatever faults are injected upstream.

Data moves as one lane-aligned beat per cycle. The beat is qualified by `in_valid`/`in_ready` at the input and by `out_valid`/`out_ready` at the output. The block has no internal buffering, so back-pressure is global. `in_ready` is `out_ready` in the same cycle. When `out_ready` is low, the input beat is not taken, and every pipeline register and balancer state holds.

A tap, `raw_valid`, shows the upstream network's output beat. It advances under the same `out_ready`, and a tap pulse counts only in a cycle where `out_ready` is high.

Top module: `bfc_corrector`

## Requirements
- R1: After a synchronous reset, `out_valid` and `raw_valid` are all zero. Every balancer is set to send its next lone token to its lower-index lane.
- R2: A token accepted while `out_ready` stays high appears on `raw_valid` log2(N)·UP_BLOCKS cycles later and on `out_valid` log2(N)·(UP_BLOCKS+FIX_STAGES) cycles later. With the defaults these are 4 and 8 cycles.
- R3: Layer l (counting from 0) of each stage pairs lane i with lane i XOR (2^(log2 N − l) − 1). A healthy balancer that receives one token sends it to the lower lane if its state says lower, and to the upper lane otherwise, and then flips its state. So a single token on lane 0 after reset leaves on lane 0 of both the tap and the output.
- R4: When two tokens reach a healthy balancer in the same cycle, one leaves on each of its lanes and its state does not change.
- R5: After traffic drains, the tap total and the output total each equal the total of accepted input tokens.
- R6: With no faults since reset, let T be the number of accepted tokens. After draining, lane i of both the tap and the output has carried floor((T − i + N − 1)/N) tokens.
- R7: While bit f of `fault_inj` is set, the balancer it controls passes each token straight through on its own lane and keeps its state. Bit f selects upstream stage f / (log2N·N/2), then layer (f / (N/2)) mod log2N, then balancer b = f mod (N/2). Balancer b of a layer whose groups have size G takes lane (b/(G/2))·G + b mod (G/2).
- R8: With FIX_STAGES ≥ log2(N), the drained output counts follow the R6 formula under any fault pattern. This includes patterns that change while tokens are in flight.
- R9: `in_ready` equals `out_ready` in the same cycle. A beat offered while `out_ready` is low is not taken. While `out_ready` is low, `out_valid`, `raw_valid` and all balancer states hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N | One token pulse per lane in the offered beat |
| in_ready | output | 1 | Beat is taken this cycle |
| out_valid | output | N | Corrected token pulses |
| out_ready | input | 1 | Downstream takes the output beat; stalls the whole block when low |
| fault_inj | input | UP_BLOCKS·log2(N)·N/2 | Per-balancer fault control for the upstream network |
| raw_valid | output | N | Tap of the upstream network's output beat |

## Verification
Three events can land in the same cycle: a stall from `out_ready`, a change of the fault pattern, and two tokens meeting at one balancer. The bench provokes this collision with a long run that randomises lane valids, ready and the fault word every few cycles. It then drains and judges the result only at the ports. The three totals must agree, and each output lane must carry exactly the step count for the number of accepted tokens.

A directed case isolates a pair arrival and checks that both tokens leave together on separate lanes. Another case stalls with tokens in flight and checks that both output beats are held.

// File: rtl/bfc_pkg.sv
`timescale 1ns/1ps
package bfc_pkg;

  // Next lane that receives a lone token from a healthy balancer.
  typedef enum logic {
    SEND_LOW  = 1'b0,
    SEND_HIGH = 1'b1
  } bal_dir_e;

  // Lower lane served by balancer b in a layer whose groups hold 2**gl lanes.
  function automatic int lane_low(int b, int gl);
    int half;
    half = 1 << (gl - 1);
    return (b / half) * (1 << gl) + (b % half);
  endfunction

  // Mirror partner of lane_low inside the same group.
  function automatic int lane_high(int b, int gl);
    int half;
    half = 1 << (gl - 1);
    return (b / half) * (1 << gl) + ((1 << gl) - 1 - (b % half));
  endfunction

endpackage

// File: rtl/bfc_bal.sv
`timescale 1ns/1ps
module bfc_bal
  import bfc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic fault,
  input  logic tok_lo,
  input  logic tok_hi,
  output logic out_lo,
  output logic out_hi
);

  bal_dir_e dir_q;
  bal_dir_e dir_d;
  logic     lone;

  always_comb begin
    lone   = tok_lo ^ tok_hi;
    dir_d  = dir_q;
    out_lo = tok_lo;
    out_hi = tok_hi;
    if (!fault && lone) begin
      out_lo = (dir_q == SEND_LOW);
      out_hi = (dir_q == SEND_HIGH);
      dir_d  = (dir_q == SEND_LOW) ? SEND_HIGH : SEND_LOW;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      dir_q <= SEND_LOW;
    else if (adv) dir_q <= dir_d;
  end

  // R3: a lone token on a healthy balancer flips its direction
  a_r3_lone_flips: assert property (@(posedge clk) disable iff (rst)
    (adv && !fault && (tok_lo != tok_hi)) |=> (dir_q != $past(dir_q)));

  // R4: a pair of tokens leaves the direction untouched
  a_r4_pair_holds: assert property (@(posedge clk) disable iff (rst)
    (adv && !fault && tok_lo && tok_hi) |=> $stable(dir_q));

  // R7: a faulted balancer keeps its direction
  a_r7_fault_freezes: assert property (@(posedge clk) disable iff (rst)
    (adv && fault) |=> $stable(dir_q));

endmodule

// File: rtl/bfc_layer.sv
`timescale 1ns/1ps
module bfc_layer
  import bfc_pkg::*;
#(
  parameter int N  = 4,
  parameter int GL = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv,
  input  logic [N/2-1:0] fault,
  input  logic [N-1:0]   d,
  output logic [N-1:0]   q
);

  localparam int HALF = N / 2;

  logic [N-1:0] nxt;

  for (genvar b = 0; b < HALF; b++) begin : g_bal
    localparam int LO = lane_low(b, GL);
    localparam int HI = lane_high(b, GL);
    bfc_bal u_bal (
      .clk    (clk),
      .rst    (rst),
      .adv    (adv),
      .fault  (fault[b]),
      .tok_lo (d[LO]),
      .tok_hi (d[HI]),
      .out_lo (nxt[LO]),
      .out_hi (nxt[HI])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (adv) q <= nxt;
  end

  // R5: a layer neither loses nor creates tokens
  a_r5_layer_conserves: assert property (@(posedge clk) disable iff (rst)
    adv |=> ($countones(q) == $past($countones(d))));

endmodule

// File: rtl/bfc_block.sv
`timescale 1ns/1ps
module bfc_block #(
  parameter int N = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        adv,
  input  logic [$clog2(N)*N/2-1:0]    fault,
  input  logic [N-1:0]                d,
  output logic [N-1:0]                q
);

  localparam int LAYERS = $clog2(N);
  localparam int HALF   = N / 2;

  logic [N-1:0] lane [LAYERS+1];

  assign lane[0] = d;

  for (genvar l = 0; l < LAYERS; l++) begin : g_layer
    bfc_layer #(
      .N  (N),
      .GL (LAYERS - l)
    ) u_layer (
      .clk   (clk),
      .rst   (rst),
      .adv   (adv),
      .fault (fault[l*HALF +: HALF]),
      .d     (lane[l]),
      .q     (lane[l+1])
    );
  end

  assign q = lane[LAYERS];

endmodule

// File: rtl/bfc_chain.sv
`timescale 1ns/1ps
module bfc_chain #(
  parameter int N      = 4,
  parameter int BLOCKS = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                adv,
  input  logic [BLOCKS*$clog2(N)*N/2-1:0]     fault,
  input  logic [N-1:0]                        d,
  output logic [N-1:0]                        q
);

  localparam int BF = $clog2(N) * N / 2;

  logic [N-1:0] link [BLOCKS+1];

  assign link[0] = d;

  for (genvar s = 0; s < BLOCKS; s++) begin : g_blk
    bfc_block #(.N(N)) u_blk (
      .clk   (clk),
      .rst   (rst),
      .adv   (adv),
      .fault (fault[s*BF +: BF]),
      .d     (link[s]),
      .q     (link[s+1])
    );
  end

  assign q = link[BLOCKS];

endmodule

// File: rtl/bfc_corrector.sv
`timescale 1ns/1ps
module bfc_corrector #(
  parameter int N          = 4,
  parameter int UP_BLOCKS  = 2,
  parameter int FIX_STAGES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [N-1:0]                         in_valid,
  output logic                                 in_ready,
  output logic [N-1:0]                         out_valid,
  input  logic                                 out_ready,
  input  logic [UP_BLOCKS*$clog2(N)*N/2-1:0]   fault_inj,
  output logic [N-1:0]                         raw_valid
);

  localparam int FIX_F = FIX_STAGES * $clog2(N) * N / 2;

  logic         adv;
  logic [N-1:0] mid;

  assign adv      = out_ready;
  assign in_ready = adv;

  bfc_chain #(
    .N      (N),
    .BLOCKS (UP_BLOCKS)
  ) u_up (
    .clk   (clk),
    .rst   (rst),
    .adv   (adv),
    .fault (fault_inj),
    .d     (in_valid),
    .q     (mid)
  );

  bfc_chain #(
    .N      (N),
    .BLOCKS (FIX_STAGES)
  ) u_fix (
    .clk   (clk),
    .rst   (rst),
    .adv   (adv),
    .fault ({FIX_F{1'b0}}),
    .d     (mid),
    .q     (out_valid)
  );

  assign raw_valid = mid;

  // R9: a stalled cycle holds both output beats
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (rst)
    !out_ready |=> ($stable(out_valid) && $stable(raw_valid)));

endmodule

// File: tb/bfc_corrector_bench.sv
`timescale 1ns/1ps
module bfc_corrector_bench;

  localparam int PERIOD = 10;
  localparam int N      = 4;
  localparam int UPF    = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   in_valid = '0;
  logic           in_ready;
  logic [N-1:0]   out_valid;
  logic           out_ready = 1'b1;
  logic [UPF-1:0] fault_inj = '0;
  logic [N-1:0]   raw_valid;

  bfc_corrector u_bfc_corrector (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .fault_inj (fault_inj),
    .raw_valid (raw_valid)
  );

  always #(PERIOD/2) clk = ~clk;

  int in_cnt  [N];
  int out_cnt [N];
  int raw_cnt [N];
  int nchk  = 0;
  int nfail = 0;

  string tag_q  [$];
  int    kind_q [$];
  int    exp_q  [$];
  event  chk_ev;

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int step_of(int t, int i);
    return (t - i + N - 1) / N;
  endfunction

  function automatic int total(int kind);
    int s = 0;
    for (int i = 0; i < N; i++)
      s += (kind == 0) ? out_cnt[i] : (kind == 1) ? raw_cnt[i] : in_cnt[i];
    return s;
  endfunction

  // Monitor: counts the transfers of the coming edge, late in the cycle.
  initial forever begin
    @(negedge clk);
    #(PERIOD/4);
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        in_cnt[i] = 0; out_cnt[i] = 0; raw_cnt[i] = 0;
      end else begin
        if (in_valid[i] && in_ready)   in_cnt[i]++;
        if (out_valid[i] && out_ready) out_cnt[i]++;
        if (raw_valid[i] && out_ready) raw_cnt[i]++;
      end
    end
  end

  // Scoreboard: pops expected per-lane counts and compares them.
  initial forever begin
    @(chk_ev);
    while (kind_q.size() > 0) begin
      int    k;
      string t;
      k = kind_q.pop_front();
      t = tag_q.pop_front();
      for (int i = 0; i < N; i++) begin
        int e;
        e = exp_q.pop_front();
        chk(t, $sformatf("%s lane %0d", (k == 1) ? "raw" : "out", i),
            (k == 1) ? raw_cnt[i] : out_cnt[i], e);
      end
    end
  end

  task automatic push_vec(string tag, int kind, int v0, int v1, int v2, int v3);
    exp_q.push_back(v0); exp_q.push_back(v1);
    exp_q.push_back(v2); exp_q.push_back(v3);
    kind_q.push_back(kind);
    tag_q.push_back(tag);
    -> chk_ev;
    #1;
  endtask

  task automatic push_step(string tag, int kind);
    int t;
    t = total(2);
    push_vec(tag, kind, step_of(t, 0), step_of(t, 1), step_of(t, 2), step_of(t, 3));
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = '0; out_ready = 1'b1; fault_inj = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drain();
    in_valid = '0; out_ready = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic sums(string tag);
    chk(tag, "raw total", total(1), total(2));
    chk(tag, "out total", total(0), total(2));
  endtask

  initial begin
    int raw_at, out_at;
    logic [N-1:0] raw_pat, out_pat, hold_raw, hold_out;

    // R1 reset state and R9 ready path
    do_reset();
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "raw_valid after reset", int'(raw_valid), 0);
    chk("R9", "in_ready with ready high", int'(in_ready), 1);
    out_ready = 1'b0; #1;
    chk("R9", "in_ready with ready low", int'(in_ready), 0);

    // R2 latency, R3 lone token on lane 0, R1 initial direction
    do_reset();
    in_valid = 4'b0001;
    raw_at = -1; out_at = -1; raw_pat = '0; out_pat = '0;
    for (int cyc = 1; cyc <= 12; cyc++) begin
      @(negedge clk);
      if (cyc == 1) in_valid = '0;
      if (raw_valid != 0 && raw_at < 0) begin raw_at = cyc; raw_pat = raw_valid; end
      if (out_valid != 0 && out_at < 0) begin out_at = cyc; out_pat = out_valid; end
    end
    chk("R2", "raw latency", raw_at, 4);
    chk("R2", "out latency", out_at, 8);
    chk("R3", "raw lane of lone token", int'(raw_pat), 1);
    chk("R1", "out lane of lone token", int'(out_pat), 1);
    drain();
    push_vec("R3", 0, 1, 0, 0, 0);

    // R4 pair arrival: lanes 0 and 1 together
    do_reset();
    in_valid = 4'b0011;
    raw_pat = '0; out_pat = '0;
    for (int cyc = 1; cyc <= 10; cyc++) begin
      @(negedge clk);
      if (cyc == 1) in_valid = '0;
      if (cyc == 4) raw_pat = raw_valid;
      if (cyc == 8) out_pat = out_valid;
    end
    chk("R4", "raw pair beat", int'(raw_pat), 3);
    chk("R4", "out pair beat", int'(out_pat), 3);

    // R6 counting without faults, R5 conservation
    do_reset();
    for (int cyc = 0; cyc < 300; cyc++) begin
      in_valid = N'($urandom);
      @(negedge clk);
    end
    drain();
    push_step("R6", 1);
    push_step("R6", 0);
    sums("R5");

    // R9 stalls: offered beats dropped, beats held, random ready
    do_reset();
    out_ready = 1'b0; in_valid = '1;
    repeat (5) @(negedge clk);
    drain();
    chk("R9", "tokens taken while stalled", total(0) + total(1), 0);
    in_valid = '1;
    repeat (6) @(negedge clk);
    in_valid = '0; out_ready = 1'b0;
    @(negedge clk);
    hold_raw = raw_valid; hold_out = out_valid;
    repeat (3) @(negedge clk);
    chk("R9", "raw beat held", int'(raw_valid), int'(hold_raw));
    chk("R9", "out beat held", int'(out_valid), int'(hold_out));
    drain();
    push_vec("R9", 0, 6, 6, 6, 6);
    for (int cyc = 0; cyc < 300; cyc++) begin
      in_valid = N'($urandom);
      out_ready = (($urandom % 10) < 6);
      @(negedge clk);
    end
    drain();
    push_step("R9", 0);
    push_step("R9", 1);

    // R7 pass-through with all upstream faults, R8 correction
    do_reset();
    fault_inj = '1;
    in_valid = 4'b1000;
    repeat (6) @(negedge clk);
    drain();
    push_vec("R7", 1, 0, 0, 0, 6);
    push_vec("R8", 0, 2, 2, 1, 1);

    // R7 frozen state: after faults clear, lane 0 still goes low
    do_reset();
    fault_inj = '1;
    in_valid = 4'b0010;
    repeat (3) @(negedge clk);
    drain();
    fault_inj = '0;
    in_valid = 4'b0001;
    @(negedge clk);
    drain();
    push_vec("R7", 1, 1, 3, 0, 0);
    push_vec("R8", 0, 1, 1, 1, 1);

    // R8 with faults changing under traffic and stalls, R5 totals
    do_reset();
    for (int cyc = 0; cyc < 400; cyc++) begin
      in_valid = N'($urandom);
      out_ready = (($urandom % 4) != 0);
      if (cyc % 7 == 0) fault_inj = UPF'($urandom);
      @(negedge clk);
    end
    drain();
    push_step("R8", 0);
    sums("R5");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule